// File: doc/BRIEF.md
# Return-Address Stack Spill/Fill Cache

This block keeps the most recent return addresses of a processor's call stack in a small ring of on-chip registers. A call pushes a 16-bit return address and a return pops one. While the entry needed is held on chip, either operation finishes in the cycle it is requested, and a popped value is presented combinationally in that same cycle.

In cycles when the processor makes no stack request, the block works toward keeping the ring about half full. When too many entries are held, it writes the oldest one out to external stack memory. When too few are held and earlier entries sit in memory, it reads the most recently written one back in. A shadow pointer tracks the top of the external stack. It moves down by two bytes for each write and up by two bytes for each read. Every external cycle carries a three-bit address-function code that marks it as return-stack traffic. Memory is modelled as answering in a single cycle: read data is valid in the cycle the read is requested.

The low and high thresholds sit a quarter of the capacity in from each end. Because of this gap, a program that alternates calls and returns inside the band never causes memory traffic.

Top module: `rs_cache`

## Requirements
- R1: While `rst` is high at a clock edge, the cache becomes empty and the shadow pointer is loaded from `rst_sp`. The first cycle after reset shows no memory request, and the first write to memory uses address `rst_sp - 2`.
- R2: A pop accepted with at least one entry cached drives the most recently pushed entry that has not yet been popped onto `cpu_rdata` in that same cycle. A push accepted with the cache not full stores `cpu_wdata` as the new top. Order is last-in, first-out.
- R3: `cpu_push` and `cpu_pop` high together, with at least one entry cached, are accepted in one cycle. `cpu_rdata` shows the old top, `cpu_wdata` replaces it, and the occupancy does not change.
- R4: In a cycle with no accepted CPU operation and an occupancy above `DEPTH - DEPTH/4` (6 by default), the block spills. It raises `mem_req` with `mem_we` = 1, drives the oldest cached entry on `mem_wdata`, and drops that entry from the cache.
- R5: In a cycle with no accepted CPU operation, an occupancy below `DEPTH/4` (2 by default) and at least one spilled entry, the block fills. It raises `mem_req` with `mem_we` = 0 and places `mem_rdata` below the oldest cached entry.
- R6: No memory request is made in a cycle where a push, pop or push+pop is accepted.
- R7: No memory request is made while the occupancy lies between `DEPTH/4` and `DEPTH - DEPTH/4`, inclusive.
- R8: `cpu_ready` goes low for a pop with zero entries cached, and for a push alone with `DEPTH` entries cached. A stalled request changes no stack state, and a spill or fill may run in its cycle. In every other case `cpu_ready` is high.
- R9: `mem_func` equals 3'b011 whenever `mem_req` is high, and 3'b000 otherwise.
- R10: A spill writes to the shadow pointer minus 2 and lowers the pointer by 2. A fill reads from the shadow pointer and raises it by 2.
- R11: No fill is made when every spilled entry has already been brought back, that is, when the pointer equals its reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_sp | input | AW | External stack top loaded at reset |
| cpu_push | input | 1 | Push request (call) |
| cpu_pop | input | 1 | Pop request (return) |
| cpu_wdata | input | DW | Return address to push |
| cpu_rdata | output | DW | Top entry, valid on an accepted pop |
| cpu_ready | output | 1 | Request accepted this cycle |
| mem_req | output | 1 | External stack cycle |
| mem_we | output | 1 | 1 = spill write, 0 = fill read |
| mem_func | output | 3 | Address-function code |
| mem_addr | output | AW | Byte address of the external cycle |
| mem_wdata | output | DW | Spilled entry |
| mem_rdata | input | DW | Filled entry, valid in the request cycle |

## Verification
The bench builds the block with its defaults: eight entries, 16-bit data and 16-bit addresses, which puts the thresholds at 2 and 6. With only eight slots, a dozen back-to-back calls fill the ring and force the full-push stall with a spill in the stalled cycle. A long run of returns then empties it, so the empty-pop stall is served by a fill. Idle stretches show the occupancy settling at each threshold, and alternating call/return bursts stay inside the band.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    // Address-function code marking return-stack traffic
    localparam logic [2:0] FUNC_RET_STACK = 3'b011;
    localparam logic [2:0] FUNC_NONE      = 3'b000;

    // What the CPU side does this cycle
    typedef enum logic [2:0] {
        OP_IDLE,
        OP_PUSH,
        OP_POP,
        OP_SWAP,
        OP_STALL
    } cpu_op_e;

    // Background memory transfer selected this cycle
    typedef enum logic [1:0] {
        XF_NONE,
        XF_SPILL,
        XF_FILL
    } xfer_e;

    // Hysteresis marks, a quarter of the capacity in from each end
    function automatic int unsigned low_mark(input int unsigned depth);
        return depth / 4;
    endfunction

    function automatic int unsigned high_mark(input int unsigned depth);
        return depth - depth / 4;
    endfunction

endpackage

// File: rtl/rsc_ring.sv
module rsc_ring #(
    parameter  int DEPTH = 8,
    parameter  int DW    = 16,
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] top_idx,
    output logic [DW-1:0] top_data,
    input  logic [IW-1:0] old_idx,
    output logic [DW-1:0] old_data
);

    logic [DW-1:0] slot [DEPTH];

    // One register per slot, each loaded only when addressed
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IW'(gi))) begin
                slot[gi] <= wr_data;
            end
        end
    end

    assign top_data = slot[top_idx];
    assign old_data = slot[old_idx];

endmodule

// File: rtl/rsc_ctrl.sv
module rsc_ctrl
    import rsc_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int IW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic          ext_has,
    output cpu_op_e       op,
    output xfer_e         xfer,
    output logic [IW-1:0] head_q,
    output logic [IW-1:0] tail_q,
    output logic [CW-1:0] occ_q,
    output logic          ready
);

    localparam logic [CW-1:0] FULL    = CW'(DEPTH);
    localparam logic [CW-1:0] LO_MARK = CW'(low_mark(DEPTH));
    localparam logic [CW-1:0] HI_MARK = CW'(high_mark(DEPTH));

    // CPU request decode with stall detection
    always_comb begin
        ready = 1'b1;
        op    = OP_IDLE;
        if (pop && (occ_q == '0)) begin
            ready = 1'b0;
            op    = OP_STALL;
        end else if (push && !pop && (occ_q == FULL)) begin
            ready = 1'b0;
            op    = OP_STALL;
        end else if (push && pop) begin
            op = OP_SWAP;
        end else if (push) begin
            op = OP_PUSH;
        end else if (pop) begin
            op = OP_POP;
        end
    end

    // Background transfer only when the CPU side is not using the ring
    always_comb begin
        xfer = XF_NONE;
        if ((op == OP_IDLE) || (op == OP_STALL)) begin
            if (occ_q > HI_MARK) begin
                xfer = XF_SPILL;
            end else if ((occ_q < LO_MARK) && ext_has) begin
                xfer = XF_FILL;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
            occ_q  <= '0;
        end else begin
            unique case (op)
                OP_PUSH: begin
                    head_q <= head_q + 1'b1;
                    occ_q  <= occ_q + 1'b1;
                end
                OP_POP: begin
                    head_q <= head_q - 1'b1;
                    occ_q  <= occ_q - 1'b1;
                end
                default: begin
                    if (xfer == XF_SPILL) begin
                        tail_q <= tail_q + 1'b1;
                        occ_q  <= occ_q - 1'b1;
                    end else if (xfer == XF_FILL) begin
                        tail_q <= tail_q - 1'b1;
                        occ_q  <= occ_q + 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/rsc_memptr.sv
module rsc_memptr
    import rsc_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] rst_sp,
    input  xfer_e         xfer,
    output logic [AW-1:0] ptr_q,
    output logic [AW-1:0] base_q,
    output logic          ext_has,
    output logic [AW-1:0] addr
);

    localparam logic [AW-1:0] STEP = AW'(2);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= rst_sp;
            base_q <= rst_sp;
        end else if (xfer == XF_SPILL) begin
            ptr_q <= ptr_q - STEP;
        end else if (xfer == XF_FILL) begin
            ptr_q <= ptr_q + STEP;
        end
    end

    assign ext_has = (ptr_q != base_q);
    assign addr    = (xfer == XF_SPILL) ? (ptr_q - STEP) : ptr_q;

endmodule

// File: rtl/rs_cache.sv
module rs_cache
    import rsc_pkg::*;
#(
    parameter  int DEPTH = 8,
    parameter  int DW    = 16,
    parameter  int AW    = 16,
    localparam int IW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] rst_sp,
    input  logic          cpu_push,
    input  logic          cpu_pop,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    output logic          cpu_ready,
    output logic          mem_req,
    output logic          mem_we,
    output logic [2:0]    mem_func,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);

    cpu_op_e       op;
    xfer_e         xfer;
    logic [IW-1:0] head, tail, top_idx, wr_idx;
    logic [CW-1:0] occ;
    logic [AW-1:0] sp_ptr, sp_base;
    logic          ext_has, wr_en;
    logic [DW-1:0] wr_data;

    rsc_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .push    (cpu_push),
        .pop     (cpu_pop),
        .ext_has (ext_has),
        .op      (op),
        .xfer    (xfer),
        .head_q  (head),
        .tail_q  (tail),
        .occ_q   (occ),
        .ready   (cpu_ready)
    );

    rsc_memptr #(.AW(AW)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .rst_sp  (rst_sp),
        .xfer    (xfer),
        .ptr_q   (sp_ptr),
        .base_q  (sp_base),
        .ext_has (ext_has),
        .addr    (mem_addr)
    );

    assign top_idx = head - 1'b1;

    // Single write port: CPU writes and fills never share a cycle
    always_comb begin
        wr_en   = 1'b0;
        wr_idx  = head;
        wr_data = cpu_wdata;
        if (op == OP_PUSH) begin
            wr_en = 1'b1;
        end else if (op == OP_SWAP) begin
            wr_en  = 1'b1;
            wr_idx = top_idx;
        end else if (xfer == XF_FILL) begin
            wr_en   = 1'b1;
            wr_idx  = tail - 1'b1;
            wr_data = mem_rdata;
        end
    end

    rsc_ring #(.DEPTH(DEPTH), .DW(DW)) u_ring (
        .clk      (clk),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .top_idx  (top_idx),
        .top_data (cpu_rdata),
        .old_idx  (tail),
        .old_data (mem_wdata)
    );

    assign mem_req  = (xfer != XF_NONE);
    assign mem_we   = (xfer == XF_SPILL);
    assign mem_func = mem_req ? FUNC_RET_STACK : FUNC_NONE;

endmodule

// File: rtl/rs_cache_chk.sv
module rs_cache_chk #(
    parameter  int DEPTH = 8,
    parameter  int AW    = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          cpu_push,
    input logic          cpu_pop,
    input logic          cpu_ready,
    input logic          mem_req,
    input logic          mem_we,
    input logic [2:0]    mem_func,
    input logic [CW-1:0] occ,
    input logic [AW-1:0] sp_ptr,
    input logic [AW-1:0] sp_base
);

    localparam logic [CW-1:0] LO = CW'(DEPTH / 4);
    localparam logic [CW-1:0] HI = CW'(DEPTH - DEPTH / 4);

    AST_NO_XFER_ON_CPU: assert property (@(posedge clk) disable iff (rst)
        ((cpu_push || cpu_pop) && cpu_ready) |-> !mem_req); // R6

    AST_SPILL_DROPS_OCC: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |=> (occ == $past(occ) - 1'b1)); // R4

    AST_FILL_RAISES_OCC: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |=> (occ == $past(occ) + 1'b1)); // R5

    AST_SPILL_LOWERS_PTR: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |=> (sp_ptr == $past(sp_ptr) - AW'(2))); // R10

    AST_FILL_RAISES_PTR: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |=> (sp_ptr == $past(sp_ptr) + AW'(2))); // R10

    AST_BAND_QUIET: assert property (@(posedge clk) disable iff (rst)
        ((occ >= LO) && (occ <= HI)) |-> !mem_req); // R7

    AST_FILL_NEEDS_SPILL: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> (sp_ptr != sp_base)); // R11

    AST_FUNC_CODE: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_func == 3'b011)); // R9

    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (rst)
        occ <= CW'(DEPTH)); // R8

endmodule

bind rs_cache rs_cache_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_push  (cpu_push),
    .cpu_pop   (cpu_pop),
    .cpu_ready (cpu_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_func  (mem_func),
    .occ       (occ),
    .sp_ptr    (sp_ptr),
    .sp_base   (sp_base)
);

// File: tb/rs_cache_bench.sv
module rs_cache_bench;

    localparam int DEPTH = 8;
    localparam int LO    = DEPTH / 4;
    localparam int HI    = DEPTH - DEPTH / 4;
    localparam logic [15:0] START = 16'h0200;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_push = 1'b0, cpu_pop = 1'b0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata, mem_addr, mem_wdata, mem_rdata;
    logic        cpu_ready, mem_req, mem_we;
    logic [2:0]  mem_func;

    int checks = 0;
    int fails  = 0;

    // Reference state: cached entries (front = oldest), spilled entries (back = newest)
    logic [15:0] q   [$];
    logic [15:0] ext [$];
    logic [15:0] mptr;
    bit          first_spill;

    logic [15:0] mem_arr [256];

    always #4 clk = ~clk;

    rs_cache u_rs_cache (
        .clk       (clk),
        .rst       (rst),
        .rst_sp    (START),
        .cpu_push  (cpu_push),
        .cpu_pop   (cpu_pop),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .cpu_ready (cpu_ready),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_func  (mem_func),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    // External stack memory: single-cycle read, write at the edge
    assign mem_rdata = mem_arr[mem_addr[8:1]];
    always @(posedge clk) begin
        if (mem_req && mem_we) mem_arr[mem_addr[8:1]] <= mem_wdata;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, check mid-low phase, update model at posedge
    task automatic step(input logic p, input logic o, input logic [15:0] d, output bit acc);
        int  n;
        bit  rdy, busy, sp, fl;
        string tag;
        cpu_push  = p;
        cpu_pop   = o;
        cpu_wdata = d;
        #2;
        n    = q.size();
        rdy  = !((o && n == 0) || (p && !o && n == DEPTH));
        busy = (p || o) && rdy;
        sp   = !busy && (n > HI);
        fl   = !busy && !sp && (n < LO) && (ext.size() > 0);
        chk("R8", {31'b0, cpu_ready}, {31'b0, rdy});
        if (o && rdy) chk(p ? "R3" : "R2", {16'b0, cpu_rdata}, {16'b0, q[$]});
        tag = busy ? "R6" : sp ? "R4" : fl ? "R5" : (n >= LO && n <= HI) ? "R7" : "R11";
        chk(tag, {31'b0, mem_req}, {31'b0, (sp || fl)});
        if (sp || fl) begin
            chk(sp ? "R4" : "R5", {31'b0, mem_we}, {31'b0, sp});
            chk("R10", {16'b0, mem_addr}, {16'b0, (sp ? mptr - 16'd2 : mptr)});
            chk("R9", {29'b0, mem_func}, 32'd3);
            if (sp) chk("R4", {16'b0, mem_wdata}, {16'b0, q[0]});
            if (sp && first_spill) begin
                chk("R1", {16'b0, mem_addr}, {16'b0, START - 16'd2});
                first_spill = 0;
            end
        end else begin
            chk("R9", {29'b0, mem_func}, 32'd0);
        end
        @(posedge clk);
        if (busy) begin
            if (o) void'(q.pop_back());
            if (p) q.push_back(d);
        end else if (sp) begin
            ext.push_back(q.pop_front());
            mptr = mptr - 16'd2;
        end else if (fl) begin
            q.push_front(ext.pop_back());
            mptr = mptr + 16'd2;
        end
        @(negedge clk);
        acc = busy;
    endtask

    task automatic do_push(input logic [15:0] d);
        bit a;
        do step(1'b1, 1'b0, d, a); while (!a);
    endtask

    task automatic do_pop();
        bit a;
        do step(1'b0, 1'b1, 16'h0, a); while (!a);
    endtask

    task automatic idle(input int k);
        bit a;
        for (int i = 0; i < k; i++) step(1'b0, 1'b0, 16'h0, a);
    endtask

    initial begin
        #(8 * 20000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        bit a;
        for (int i = 0; i < 256; i++) mem_arr[i] = '0;
        mptr = START;
        first_spill = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        // R1: empty after reset, no memory traffic
        chk("R1", {31'b0, mem_req}, 32'd0);
        @(negedge clk);
        idle(1);
        step(1'b0, 1'b1, 16'h0, a);           // R8/R11: pop on empty, nothing spilled
        for (int i = 0; i < 12; i++) do_push(16'h1000 + 16'(i));   // full stall + spills
        idle(4);                               // settle to HI
        for (int i = 0; i < 10; i++) begin     // R7: alternate inside band
            do_push(16'h2000 + 16'(i));
            do_pop();
        end
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 16'h3000 + 16'(i), a);  // R3
        while (q.size() + ext.size() > 0) do_pop();   // empty-pop stalls with fills
        idle(3);                               // R11
        for (int i = 0; i < 9; i++) do_push(16'h4000 + 16'(i));
        idle(5);
        for (int i = 0; i < 5; i++) do_pop();
        idle(4);                               // R5: idle fills up to LO
        while (q.size() + ext.size() > 0) do_pop();
        idle(2);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule